// File: doc/BRIEF.md
# SPI Master Controller with Word Register Port

This block is a serial peripheral interface master driven by a 32-bit word read/write port. Software writes transmit words into a queue and reads received words from a second queue of the same depth. It programs the clock polarity, clock phase, bit order, loopback and slave-select behaviour through a control word, and watches progress through a status word and a latched interrupt unit. A hold bit keeps words queued without shifting them, so a burst can be loaded completely before the serial clock starts.

The serial clock runs at the system clock divided by `CLK_DIV`. Each word is `DATA_W` bits long. Each shifted word pushes exactly one received word into the receive queue. In automatic select mode the programmed select pattern appears on the select lines only while a word is being shifted. In manual select mode the pattern follows the select register at all times. Interrupt sources latch on events, clear when software writes ones back to them, and reach `irq_o` through per-source enables and a global enable.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the status word reads 0x05 (bit 0 receive empty, bit 2 transmit empty). The control word reads 0. The select register reads all ones. All select lines are high, `sclk_o` is low and `irq_o` is low.
- R2: A write to offset 0x68 queues one word when the transmit queue has room. Status bit 3 (transmit full) is set once `FIFO_DEPTH` words are queued. A write made while the queue is full is dropped.
- R3: While control bit 8 (hold) is set, queued words stay queued and no serial clock edge occurs. Clearing the bit starts draining the queue.
- R4: Every completed word pushes one received word into the receive queue. A read of offset 0x6C returns the oldest received word, zero-extended, and pops it. Status bit 1 is set while the receive queue holds `FIFO_DEPTH` words.
- R5: Control bit 3 sets the idle level of `sclk_o`. With control bit 4 clear, data is sampled on the first edge of each clock period and launched on the second. With bit 4 set, data is launched on the first edge and sampled on the second. Bits go out most significant first by default.
- R6: Control bit 9 set makes both the transmit and the receive shifting run least significant bit first.
- R7: Control bit 0 set returns `mosi_o` into the receiver in place of `miso_i`.
- R8: The select register at 0x70 holds one bit per slave, and a 0 bit drives that slave's line low. With control bit 7 (manual) set, the lines follow the register on every cycle. Otherwise they show the register only while a word is shifting and stay high between words.
- R9: Status bit 2 (transmit empty) and interrupt source bit 2 are set only when the last queued word has finished shifting.
- R10: Interrupt status at 0x20 clears the bits written as one. The source enable is at 0x28 and the global enable is bit 31 of 0x1C. `irq_o` is one cycle after any enabled, set status bit, and only while the global enable is on.
- R11: Interrupt source bit 4 sets when the receive queue becomes full. Source bit 5 sets when a word completes while the receive queue is full, and that word is dropped. Source bit 6 sets when the transmit queue falls to half its depth.
- R12: Writing 0x0A to offset 0x40 returns every register and both queues to their reset values. Any other value written there has no effect.
- R13: Writing control bit 5 empties the transmit queue and writing control bit 6 empties the receive queue. Both bits read back as 0.
- R14: Shifting starts only while control bit 1 (enable) and bit 2 (master) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Interrupt request, active high |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to slaves |
| miso_i | input | 1 | Serial data from slaves |
| ss_no | output | NUM_SS | Slave select lines, active low |

## Verification
The assertions watch, on every cycle, that neither queue count goes past the depth and that a word never starts while the hold bit is set. They also check that a completed word raises the receive count by one when there is room, and raises the overrun source when there is not. Finally, they check that a write-one clear removes the transmit-empty source and that the interrupt output stays low one cycle after the global enable was off. The bench scenarios are needed for the rest. These are the bit order and edge choice in all four clock modes, loopback against an inverting external slave, and the dropped writes to a full queue. They also cover the exact set of latched sources after a burst, the select line timing in both modes, and the soft reset key.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam logic [7:0] OFS_GIE  = 8'h1C;
  localparam logic [7:0] OFS_ISR  = 8'h20;
  localparam logic [7:0] OFS_IER  = 8'h28;
  localparam logic [7:0] OFS_SRST = 8'h40;
  localparam logic [7:0] OFS_CTRL = 8'h60;
  localparam logic [7:0] OFS_STAT = 8'h64;
  localparam logic [7:0] OFS_TXD  = 8'h68;
  localparam logic [7:0] OFS_RXD  = 8'h6C;
  localparam logic [7:0] OFS_SSEL = 8'h70;

  localparam logic [31:0] SRST_KEY = 32'h0000_000A;

  localparam int unsigned IRQ_W    = 7;
  localparam int unsigned IRQ_TXE  = 2;
  localparam int unsigned IRQ_RXF  = 4;
  localparam int unsigned IRQ_OVR  = 5;
  localparam int unsigned IRQ_HALF = 6;

  typedef struct packed {
    logic lsb_first;
    logic hold;
    logic manual_ss;
    logic cpha;
    logic cpol;
    logic master;
    logic enable;
    logic loopback;
  } ctrl_t;
endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr] <= wdata_i;
  end
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
  parameter int unsigned W       = 8,
  parameter int unsigned CLK_DIV = 4,
  localparam int unsigned HALF   = (CLK_DIV / 2 > 0) ? CLK_DIV / 2 : 1,
  localparam int unsigned DW     = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int unsigned EW     = $clog2(2 * W),
  localparam int unsigned BW     = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         start_i,
  input  logic [W-1:0] data_i,
  input  logic         cpol_i,
  input  logic         cpha_i,
  input  logic         lsb_i,
  input  logic         loop_i,
  input  logic         miso_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] rx_o,
  output logic         sclk_o,
  output logic         mosi_o
);
  logic          busy_q, lvl_q;
  logic [DW-1:0] div_q;
  logic [EW-1:0] edge_q;
  logic [BW-1:0] bit_q, out_pos;
  logic [W-1:0]  tx_q, rx_q, rx_next;
  logic          edge_now, leading, sample, launch, last, rx_bit;

  assign edge_now = busy_q && (div_q == DW'(HALF - 1));
  assign leading  = !edge_q[0];
  assign sample   = edge_now && (leading ^ cpha_i);
  // CPHA=1 launches on leading edges after the first; CPHA=0 on trailing edges but the last
  assign launch   = edge_now && (cpha_i ? (leading && edge_q != '0)
                                        : (!leading && edge_q != EW'(2 * W - 1)));
  assign last     = edge_now && (edge_q == EW'(2 * W - 1));
  assign out_pos  = lsb_i ? bit_q : BW'(W - 1) - bit_q;
  assign mosi_o   = tx_q[out_pos];
  assign rx_bit   = loop_i ? mosi_o : miso_i;
  assign rx_next  = lsb_i ? {rx_bit, rx_q[W-1:1]} : {rx_q[W-2:0], rx_bit};
  assign rx_o     = sample ? rx_next : rx_q;
  assign done_o   = last;
  assign busy_o   = busy_q;
  assign sclk_o   = cpol_i ^ lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      lvl_q  <= 1'b0;
      div_q  <= '0;
      edge_q <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      lvl_q  <= 1'b0;
      div_q  <= '0;
      edge_q <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      lvl_q  <= 1'b0;
      div_q  <= '0;
      edge_q <= '0;
      bit_q  <= '0;
      tx_q   <= data_i;
    end else if (busy_q) begin
      div_q <= edge_now ? '0 : div_q + 1'b1;
      if (edge_now) begin
        lvl_q  <= ~lvl_q;
        edge_q <= edge_q + 1'b1;
      end
      if (sample) rx_q <= rx_next;
      if (launch) bit_q <= bit_q + 1'b1;
      if (last) begin
        busy_q <= 1'b0;
        lvl_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int unsigned NUM_SS     = 4,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CLK_DIV    = 4,
  localparam int unsigned CNTW      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_no
);
  ctrl_t              ctrl_q;
  logic [NUM_SS-1:0]  ssel_q;
  logic               gie_q, irq_q;
  logic [IRQ_W-1:0]   ier_q, isr_q, isr_set, isr_clr;

  logic               wr, rd, srst, tx_clr, rx_clr;
  logic               tx_push, tx_empty_f, tx_full_f, start;
  logic               rx_pop, rx_empty_f, rx_full_f;
  logic [DATA_W-1:0]  tx_head, rx_head, rx_word;
  logic [CNTW-1:0]    tx_cnt, rx_cnt;
  logic               busy, done;
  logic               tx_empty_evt, rx_full_evt, ovr_evt, half_evt;

  assign wr   = req_i && we_i;
  assign rd   = req_i && !we_i;
  assign srst = wr && (addr_i == OFS_SRST) && (wdata_i == SRST_KEY);
  wire ctrl_wr = wr && (addr_i == OFS_CTRL);
  assign tx_clr  = srst || (ctrl_wr && wdata_i[5]);
  assign rx_clr  = srst || (ctrl_wr && wdata_i[6]);
  assign tx_push = wr && (addr_i == OFS_TXD);
  assign rx_pop  = rd && (addr_i == OFS_RXD) && !rx_empty_f;
  assign start   = ctrl_q.enable && ctrl_q.master && !ctrl_q.hold && !busy && !tx_empty_f;

  spi_host_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
    .clk_i, .rst_ni, .clr_i(tx_clr), .push_i(tx_push), .pop_i(start),
    .wdata_i(wdata_i[DATA_W-1:0]), .rdata_o(tx_head),
    .empty_o(tx_empty_f), .full_o(tx_full_f), .count_o(tx_cnt)
  );

  spi_host_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni, .clr_i(rx_clr), .push_i(done), .pop_i(rx_pop),
    .wdata_i(rx_word), .rdata_o(rx_head),
    .empty_o(rx_empty_f), .full_o(rx_full_f), .count_o(rx_cnt)
  );

  spi_host_shifter #(.W(DATA_W), .CLK_DIV(CLK_DIV)) i_shifter (
    .clk_i, .rst_ni, .clr_i(srst), .start_i(start), .data_i(tx_head),
    .cpol_i(ctrl_q.cpol), .cpha_i(ctrl_q.cpha), .lsb_i(ctrl_q.lsb_first),
    .loop_i(ctrl_q.loopback), .miso_i, .busy_o(busy), .done_o(done),
    .rx_o(rx_word), .sclk_o, .mosi_o
  );

  assign tx_empty_evt = done && tx_empty_f;
  assign rx_full_evt  = done && !rx_full_f && !rx_pop && (rx_cnt == CNTW'(FIFO_DEPTH - 1));
  assign ovr_evt      = done && rx_full_f;
  assign half_evt     = start && (tx_cnt == CNTW'(FIFO_DEPTH / 2 + 1));

  always_comb begin
    isr_set           = '0;
    isr_set[IRQ_TXE]  = tx_empty_evt;
    isr_set[IRQ_RXF]  = rx_full_evt;
    isr_set[IRQ_OVR]  = ovr_evt;
    isr_set[IRQ_HALF] = half_evt;
    isr_clr = (wr && addr_i == OFS_ISR) ? wdata_i[IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ssel_q <= '1;
      gie_q  <= 1'b0;
      ier_q  <= '0;
      isr_q  <= '0;
      irq_q  <= 1'b0;
    end else if (srst) begin
      ctrl_q <= '0;
      ssel_q <= '1;
      gie_q  <= 1'b0;
      ier_q  <= '0;
      isr_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q <= '{lsb_first: wdata_i[9], hold: wdata_i[8], manual_ss: wdata_i[7],
                    cpha: wdata_i[4], cpol: wdata_i[3], master: wdata_i[2],
                    enable: wdata_i[1], loopback: wdata_i[0]};
      end
      if (wr && addr_i == OFS_SSEL) ssel_q <= wdata_i[NUM_SS-1:0];
      if (wr && addr_i == OFS_GIE)  gie_q  <= wdata_i[31];
      if (wr && addr_i == OFS_IER)  ier_q  <= wdata_i[IRQ_W-1:0];
      isr_q <= (isr_q & ~isr_clr) | isr_set;
      irq_q <= gie_q && |(isr_q & ier_q);
    end
  end

  assign irq_o = irq_q;
  assign ss_no = (ctrl_q.manual_ss || busy) ? ssel_q : '1;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: rdata_o[9:0] = {ctrl_q.lsb_first, ctrl_q.hold, ctrl_q.manual_ss, 2'b00,
                                ctrl_q.cpha, ctrl_q.cpol, ctrl_q.master,
                                ctrl_q.enable, ctrl_q.loopback};
      OFS_STAT: rdata_o[4:0] = {1'b0, tx_full_f, tx_empty_f && !busy, rx_full_f, rx_empty_f};
      OFS_RXD:  rdata_o[DATA_W-1:0] = rx_head;
      OFS_SSEL: rdata_o[NUM_SS-1:0] = ssel_q;
      OFS_GIE:  rdata_o[31] = gie_q;
      OFS_ISR:  rdata_o[IRQ_W-1:0] = isr_q;
      OFS_IER:  rdata_o[IRQ_W-1:0] = ier_q;
      default:  rdata_o = '0;
    endcase
  end

  wire unused_wdata = ^{wdata_i[30:10], wdata_i[3:2]};
endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNTW  = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_i,
  input logic            done_i,
  input logic            hold_i,
  input logic [CNTW-1:0] tx_cnt_i,
  input logic [CNTW-1:0] rx_cnt_i,
  input logic            rx_full_i,
  input logic            rx_pop_i,
  input logic            isr_wr_i,
  input logic [6:0]      isr_wdata_i,
  input logic            tx_empty_evt_i,
  input logic [6:0]      isr_i,
  input logic            gie_i,
  input logic            irq_i
);
  p_queue_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt_i <= CNTW'(DEPTH)) && (rx_cnt_i <= CNTW'(DEPTH)));

  p_no_start_on_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !$past(hold_i));

  p_rx_push_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !rx_full_i && !rx_pop_i |=> rx_cnt_i == $past(rx_cnt_i) + 1'b1);

  p_overrun_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && rx_full_i |=> isr_i[5]);

  p_w1c_txe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_wr_i && isr_wdata_i[2] && !tx_empty_evt_i |=> !isr_i[2]);

  p_irq_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(gie_i) |-> !irq_i);
endmodule

bind spi_host_ctrl spi_host_ctrl_chk #(.DEPTH(FIFO_DEPTH), .CNTW(CNTW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .done_i(done), .hold_i(ctrl_q.hold),
  .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt), .rx_full_i(rx_full_f), .rx_pop_i(rx_pop),
  .isr_wr_i(wr && addr_i == spi_host_pkg::OFS_ISR), .isr_wdata_i(wdata_i[6:0]),
  .tx_empty_evt_i(tx_empty_evt), .isr_i(isr_q), .gie_i(gie_q), .irq_i(irq_o)
);

// File: tb/test_spi_host_ctrl.sv
module test_spi_host_ctrl;
  import spi_host_pkg::*;

  localparam int NSS = 4;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, sclk, mosi, miso;
  logic [NSS-1:0] ss_n;

  always #5 clk = ~clk;
  assign miso = ~mosi;  // external slave echoes inverted data

  spi_host_ctrl #(.NUM_SS(NSS), .FIFO_DEPTH(DEPTH), .DATA_W(8), .CLK_DIV(4)) i_spi_host_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .ss_no(ss_n)
  );

  int total = 0, fails = 0;
  logic [7:0] exp_q[$];
  logic m_cpol = 0, m_cpha = 0, m_lsb = 0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    bus_rd(a, d);
    check(d === exp, tag, d, exp);
  endtask

  // scoreboard driver: queue the expected serial word, then write it
  task automatic send(input logic [7:0] b);
    exp_q.push_back(b);
    bus_wr(OFS_TXD, {24'h0, b});
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 3000; i++) begin
      bus_rd(OFS_STAT, d);
      if (d[2]) return;
    end
    check(1'b0, "R9 idle timeout", d, 32'h4);
  endtask

  task automatic set_mode(input logic [31:0] ctrl);
    m_cpol = ctrl[3]; m_cpha = ctrl[4]; m_lsb = ctrl[9];
    bus_wr(OFS_CTRL, ctrl);
  endtask

  // scoreboard monitor: rebuilds serial words from MOSI on sampling edges
  logic prev_sclk = 0, prev_act = 0;
  logic [7:0] mon_w = '0;
  int mon_n = 0;
  always @(negedge clk) begin
    if (prev_act && sclk != prev_sclk && (sclk ^ m_cpol ^ m_cpha)) begin
      mon_w = m_lsb ? {mosi, mon_w[7:1]} : {mon_w[6:0], mosi};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) check(1'b0, "R5 R6 unexpected word", {24'h0, mon_w}, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(mon_w === e, "R5 R6 serial word", {24'h0, mon_w}, {24'h0, e});
        end
      end
    end
    prev_sclk = sclk;
    prev_act  = (ss_n != '1);
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    expect_rd(OFS_STAT, 32'h5, "R1 status");
    expect_rd(OFS_CTRL, 32'h0, "R1 ctrl");
    expect_rd(OFS_SSEL, 32'hF, "R1 select reg");
    check(ss_n === 4'hF && sclk === 1'b0 && irq === 1'b0, "R1 pins", {ss_n, sclk, irq}, 32'h3C);

    // R14: enable without master does not shift
    set_mode(32'h002);
    bus_wr(OFS_TXD, 32'h11);
    repeat (60) @(negedge clk);
    expect_rd(OFS_STAT, 32'h1, "R14 no shift without master");
    // R13: queue resets
    bus_wr(OFS_CTRL, 32'h062);
    expect_rd(OFS_STAT, 32'h5, "R13 tx queue emptied");
    expect_rd(OFS_CTRL, 32'h002, "R13 reset bits read 0");

    // R3 hold, R8 auto select
    bus_wr(OFS_SSEL, 32'hE);
    check(ss_n === 4'hF, "R8 idle lines high", ss_n, 4'hF);
    set_mode(32'h106);
    send(8'hA5);
    send(8'h3C);
    repeat (80) @(negedge clk);
    check(sclk === 1'b0, "R3 no clock on hold", sclk, 0);
    expect_rd(OFS_STAT, 32'h1, "R3 words held");
    set_mode(32'h006);
    repeat (12) @(negedge clk);
    check(ss_n === 4'hE, "R8 select during word", ss_n, 4'hE);
    expect_rd(OFS_STAT, 32'h1, "R9 not empty mid word");
    wait_idle();
    check(ss_n === 4'hF, "R8 released after word", ss_n, 4'hF);
    expect_rd(OFS_RXD, 32'h5A, "R7 external miso word 0");
    expect_rd(OFS_RXD, 32'hC3, "R4 external miso word 1");
    expect_rd(OFS_STAT, 32'h5, "R4 rx drained");

    // R5 R6 R7 across modes
    for (int m = 0; m < 8; m++) begin
      logic [7:0] b;
      logic [31:0] c;
      b = 8'h1D + 8'(m * 37);
      c = 32'h006 | (32'(m[0]) << 3) | (32'(m[1]) << 4) | (32'(m[2]) << 9) | 32'(m[0] ^ m[2]);
      set_mode(c);
      check(sclk === m[0], "R5 idle level", sclk, m[0]);
      send(b);
      wait_idle();
      expect_rd(OFS_RXD, (m[0] ^ m[2]) ? {24'h0, b} : {24'h0, ~b}, "R7 R6 received word");
    end
    check(exp_q.size() == 0, "R5 all words seen", exp_q.size(), 0);

    // R2 depth, R11 R9 sources
    set_mode(32'h106);
    bus_wr(OFS_ISR, 32'h7F);
    n = 0;
    do begin
      send(8'h40 + 8'(n));
      n++;
      bus_rd(OFS_STAT, d);
    end while (!d[3] && n < 10);
    check(n == DEPTH, "R2 depth by full flag", n, DEPTH);
    bus_wr(OFS_TXD, 32'hEE);  // dropped
    bus_wr(OFS_IER, 32'h74);
    bus_wr(OFS_GIE, 32'h8000_0000);
    set_mode(32'h006);
    wait_idle();
    expect_rd(OFS_STAT, 32'h6, "R4 rx full flag");
    expect_rd(OFS_ISR, 32'h54, "R11 R9 latched sources");
    check(irq === 1'b1, "R10 irq raised", irq, 1);
    for (int i = 0; i < DEPTH; i++) expect_rd(OFS_RXD, {24'h0, ~(8'h40 + 8'(i))}, "R2 queued words");
    expect_rd(OFS_STAT, 32'h5, "R2 extra write dropped");

    // R10 write-one clear and global gate
    bus_wr(OFS_ISR, 32'h04);
    expect_rd(OFS_ISR, 32'h50, "R10 clears only written bit");
    bus_wr(OFS_ISR, 32'h50);
    repeat (2) @(negedge clk);
    check(irq === 1'b0, "R10 irq cleared", irq, 0);
    bus_wr(OFS_GIE, 32'h0);
    send(8'h77);
    wait_idle();
    repeat (2) @(negedge clk);
    expect_rd(OFS_ISR, 32'h04, "R9 tx empty source");
    check(irq === 1'b0, "R10 global gate off", irq, 0);
    bus_wr(OFS_GIE, 32'h8000_0000);
    repeat (2) @(negedge clk);
    check(irq === 1'b1, "R10 global gate on", irq, 1);

    // R11 overrun: one word still held in rx
    bus_wr(OFS_ISR, 32'h7F);
    set_mode(32'h106);
    for (int i = 0; i < DEPTH; i++) send(8'h90 + 8'(i));
    set_mode(32'h006);
    wait_idle();
    expect_rd(OFS_ISR, 32'h74, "R11 overrun and full sources");
    expect_rd(OFS_RXD, 32'h88, "R11 oldest word kept");
    for (int i = 0; i < DEPTH - 1; i++) expect_rd(OFS_RXD, {24'h0, ~(8'h90 + 8'(i))}, "R11 words before overrun");
    expect_rd(OFS_STAT, 32'h5, "R11 overrun word dropped");

    // R8 manual select
    bus_wr(OFS_CTRL, 32'h086);
    bus_wr(OFS_SSEL, 32'hA);
    check(ss_n === 4'hA, "R8 manual follows register", ss_n, 4'hA);

    // R12 soft reset
    bus_wr(OFS_IER, 32'h3);
    bus_wr(OFS_SRST, 32'h5);
    expect_rd(OFS_CTRL, 32'h086, "R12 wrong key ignored");
    bus_wr(OFS_SRST, 32'h0A);
    expect_rd(OFS_CTRL, 32'h0, "R12 ctrl restored");
    expect_rd(OFS_SSEL, 32'hF, "R12 select restored");
    expect_rd(OFS_IER, 32'h0, "R12 enables restored");
    expect_rd(OFS_GIE, 32'h0, "R12 global restored");
    expect_rd(OFS_STAT, 32'h5, "R12 status restored");
    check(ss_n === 4'hF, "R12 lines high", ss_n, 4'hF);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule